// File: doc/BRIEF.md
# Character LCD Refresh Sequencer

This block drives a 20-column, two-row character LCD over its 8-bit parallel write bus. It never reads the panel and never polls a busy flag. Instead it runs free on a fixed slot grid. Every two clocks of the nominal 10 kHz clock form one 0.2 ms slot, and each slot carries at most one bus write. The strobe is centred in the slot: it rises half a clock after data and RS settle, and it falls half a clock before they change.

After reset the block spends one full pass on the controller's start-up command list. It then loops forever over refresh passes. Each pass is four groups. Each group is a cursor-address command followed by one write per column. Even groups repaint the top row from a fixed banner parameter. Odd groups repaint the bottom row from a packed vector of 4-bit digit codes. These codes are converted to ASCII, and the vector is captured once at the start of each odd group. A pass has 84 slots, which is 16.8 ms at the nominal clock.

Top module: `lcd_refresh_seq`

## Requirements
- R1: `lcd_rw` is 0 in every cycle, in reset and out of it.
- R2: A slot is two clock cycles. `lcd_data` and `lcd_rs` change only on the rising edge that opens a slot, and they hold through the slot's second cycle.
- R3: `lcd_e` is high only in write slots. It goes high on the falling clock edge in the slot's first cycle and low on the falling edge in its second cycle. It is never high at two consecutive rising edges.
- R4: After reset, slots 0 to 7 write the commands 0x3C, 0x3C, 0x3C, 0x3C, 0x01, 0x06, 0x0C, 0x80 in that order, each with `lcd_rs` = 0.
- R5: Slots 8 to 83 of the start-up pass produce no strobe. In these slots `lcd_rs` and `lcd_data` are 0.
- R6: From slot 84 on, the slots repeat in passes of 84, each pass being four groups of 21. The first slot of group g is a command with `lcd_rs` = 0 and data 0x80 OR the row base. The row base is 0x00 when g is even and 0x40 when g is odd.
- R7: In an even group, slot c (1 to 20) writes banner byte c-1 with `lcd_rs` = 1. Banner byte 0 is the most significant byte of the `BANNER` parameter.
- R8: In an odd group, slot c (1 to 20) writes a character with `lcd_rs` = 1. The character comes from the code v in `digits_i[4(c-1)+3 : 4(c-1)]`. It is 0x30+v when v is 9 or less, and 0x20 (space) otherwise.
- R9: `digits_i` is captured on the rising edge that opens an odd group's address slot. A change after that edge shows up only from the next odd group.
- R10: While `rst_n` is low, `lcd_e`, `lcd_rs` and `lcd_data` are 0 without waiting for a clock. After release the sequence restarts at slot 0 (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock (nominally 10 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits_i | input | 80 | Bottom-row digit codes, 4 bits per column, column 0 in the low nibble |
| lcd_e | output | 1 | Write strobe, high for the middle half of a write slot |
| lcd_rs | output | 1 | 0 for command, 1 for character |
| lcd_rw | output | 1 | Read/write select, held low |
| lcd_data | output | 8 | Command or character byte |

## Verification
Data and RS for a slot are due on the rising edge that opens it. The strobe is due one falling edge later and drops on the following falling edge. The bench therefore samples every output 2 ns after each rising edge and 2 ns after each falling edge. It compares them against a behavioural slot-count model that advances on the same rising edges. A digit change is due only from the next odd group's opening edge. For this reason the model latches `digits_i` on that edge alone, and the bench changes the digits on purpose in the middle of an odd group.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   localparam int INIT_LEN = 8;
   localparam int NUM_GROUPS = 4;

   localparam logic [7:0] CMD_FUNC_SET = 8'h3C;
   localparam logic [7:0] CMD_CLEAR    = 8'h01;
   localparam logic [7:0] CMD_ENTRY    = 8'h06;
   localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
   localparam logic [7:0] CMD_SET_ADDR = 8'h80;
   localparam logic [7:0] CHAR_BLANK   = 8'h20;
   localparam logic [7:0] CHAR_ZERO    = 8'h30;

   typedef enum logic {SEQ_INIT = 1'b0, SEQ_RUN = 1'b1} seq_mode_e;

   typedef struct packed {
      logic       pulse;
      logic       rs;
      logic [7:0] data;
   } bus_word_t;

   // start-up command list, position in the list selects the command
   function automatic logic [7:0] init_cmd(input logic [2:0] idx);
      case (idx)
         3'd0, 3'd1, 3'd2, 3'd3: init_cmd = CMD_FUNC_SET;
         3'd4:                   init_cmd = CMD_CLEAR;
         3'd5:                   init_cmd = CMD_ENTRY;
         3'd6:                   init_cmd = CMD_DISP_ON;
         default:                init_cmd = CMD_SET_ADDR;
      endcase
   endfunction

   // decimal code to display character, anything out of range shows blank
   function automatic logic [7:0] nibble_char(input logic [3:0] v);
      if (v <= 4'd9) nibble_char = CHAR_ZERO + {4'h0, v};
      else           nibble_char = CHAR_BLANK;
   endfunction

endpackage

// File: rtl/lcd_slot_phase.sv
module lcd_slot_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic slot_start_o,
   output logic lcd_e_o
);

   logic ph_q;

   // ph_q is 1 during the second cycle of a slot: the next rising edge opens a slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b1;
      else        ph_q <= ~ph_q;
   end

   assign slot_start_o = ph_q;

   // strobe on the falling edge so it sits half a clock inside the slot on both sides
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) lcd_e_o <= 1'b0;
      else        lcd_e_o <= pulse_i & ~ph_q;
   end

endmodule

// File: rtl/lcd_slot_counter.sv
module lcd_slot_counter
   import lcd_seq_pkg::*;
#(
   parameter int NUM_COLS = 20,
   parameter int COL_W    = $clog2(NUM_COLS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [COL_W-1:0] col_o,
   output logic [1:0]       line_o,
   output seq_mode_e        mode_o
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_o  <= '0;
         line_o <= '0;
         mode_o <= SEQ_INIT;
      end else if (adv_i) begin
         if (col_o == COL_LAST) begin
            col_o  <= '0;
            line_o <= line_o + 2'd1;
            if (line_o == 2'd3) mode_o <= SEQ_RUN;
         end else begin
            col_o <= col_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lcd_char_source.sv
module lcd_char_source
   import lcd_seq_pkg::*;
#(
   parameter int                    NUM_COLS = 20,
   parameter int                    COL_W    = $clog2(NUM_COLS + 1),
   parameter logic [NUM_COLS*8-1:0] BANNER   = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture_i,
   input  logic [NUM_COLS*4-1:0] digits_i,
   input  logic [COL_W-1:0]      col_i,
   input  logic                  odd_line_i,
   output logic [7:0]            char_o
);

   logic [NUM_COLS*4-1:0] shadow_q;
   logic [7:0]            digit_chars  [NUM_COLS];
   logic [7:0]            banner_chars [NUM_COLS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shadow_q <= '0;
      else if (capture_i) shadow_q <= digits_i;
   end

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign digit_chars[c]  = nibble_char(shadow_q[c*4 +: 4]);
      assign banner_chars[c] = BANNER[(NUM_COLS-1-c)*8 +: 8];
   end

   // column 0 of a group is the address slot, characters start at column 1
   always_comb begin
      char_o = CHAR_BLANK;
      for (int c = 0; c < NUM_COLS; c++) begin
         if (col_i == COL_W'(c + 1)) char_o = odd_line_i ? digit_chars[c] : banner_chars[c];
      end
   end

endmodule

// File: rtl/lcd_refresh_seq.sv
module lcd_refresh_seq
   import lcd_seq_pkg::*;
#(
   parameter int                    NUM_COLS   = 20,
   parameter logic [7:0]            LINE0_BASE = 8'h00,
   parameter logic [7:0]            LINE1_BASE = 8'h40,
   parameter logic [NUM_COLS*8-1:0] BANNER     = "   LCD REFRESH UNIT "
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_COLS*4-1:0] digits_i,
   output logic                  lcd_e,
   output logic                  lcd_rs,
   output logic                  lcd_rw,
   output logic [7:0]            lcd_data
);

   localparam int COL_W     = $clog2(NUM_COLS + 1);
   localparam int GROUP_LEN = NUM_COLS + 1;
   localparam int PASS_LEN  = NUM_GROUPS * GROUP_LEN;
   localparam int IDX_W     = $clog2(PASS_LEN);

   if (NUM_COLS < 1 || NUM_COLS > 40) begin : g_bad_cols
      $error("NUM_COLS must lie in 1..40");
   end
   if (int'(LINE1_BASE) < int'(LINE0_BASE) + NUM_COLS) begin : g_bad_base
      $error("row address ranges overlap");
   end
   if (int'(LINE1_BASE) + NUM_COLS > 128) begin : g_bad_range
      $error("row address range exceeds 7 bits");
   end

   logic             slot_start;
   logic [COL_W-1:0] col_q;
   logic [1:0]       line_q;
   seq_mode_e        mode_q;
   logic             run_mode;
   logic [IDX_W-1:0] slot_idx;
   logic [7:0]       char_byte;
   logic             capture;
   bus_word_t        next_word;
   bus_word_t        bus_q;

   lcd_slot_phase u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .pulse_i      (bus_q.pulse),
      .slot_start_o (slot_start),
      .lcd_e_o      (lcd_e)
   );

   lcd_slot_counter #(
      .NUM_COLS (NUM_COLS),
      .COL_W    (COL_W)
   ) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (slot_start),
      .col_o  (col_q),
      .line_o (line_q),
      .mode_o (mode_q)
   );

   assign run_mode = (mode_q == SEQ_RUN);
   assign capture  = slot_start & run_mode & (col_q == '0) & line_q[0];

   lcd_char_source #(
      .NUM_COLS (NUM_COLS),
      .COL_W    (COL_W),
      .BANNER   (BANNER)
   ) u_chars (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_i  (capture),
      .digits_i   (digits_i),
      .col_i      (col_q),
      .odd_line_i (line_q[0]),
      .char_o     (char_byte)
   );

   assign slot_idx = IDX_W'(line_q) * IDX_W'(GROUP_LEN) + IDX_W'(col_q);

   always_comb begin
      next_word = '0;
      if (!run_mode) begin
         if (slot_idx < IDX_W'(INIT_LEN)) begin
            next_word.pulse = 1'b1;
            next_word.data  = init_cmd(slot_idx[2:0]);
         end
      end else if (col_q == '0) begin
         next_word.pulse = 1'b1;
         next_word.data  = CMD_SET_ADDR | (line_q[0] ? LINE1_BASE : LINE0_BASE);
      end else begin
         next_word.pulse = 1'b1;
         next_word.rs    = 1'b1;
         next_word.data  = char_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bus_q <= '0;
      else if (slot_start) bus_q <= next_word;
   end

   assign lcd_rs   = bus_q.rs;
   assign lcd_data = bus_q.data;
   assign lcd_rw   = 1'b0;

endmodule

// File: rtl/lcd_refresh_seq_chk.sv
module lcd_refresh_seq_chk #(
   parameter int         NUM_COLS   = 20,
   parameter logic [7:0] LINE0_BASE = 8'h00,
   parameter logic [7:0] LINE1_BASE = 8'h40,
   parameter int         COL_W      = $clog2(NUM_COLS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slot_start,
   input logic [COL_W-1:0] col_q,
   input logic [1:0]       line_q,
   input logic             mode_run,
   input logic             lcd_e,
   input logic             lcd_rs,
   input logic             lcd_rw,
   input logic [7:0]       lcd_data
);

   logic in_cmd_list;
   assign in_cmd_list = (int'(line_q) * (NUM_COLS + 1) + int'(col_q)) < 8;

   p_rw_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_rw == 1'b0);

   p_mid_slot_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_start |=> ($stable(lcd_data) && $stable(lcd_rs)));

   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_e |=> !lcd_e);

   p_strobe_mid_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_e |-> !slot_start);

   p_init_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && !mode_run && in_cmd_list) |=> (lcd_e && !lcd_rs));

   p_init_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && !mode_run && !in_cmd_list) |=> !lcd_e);

   p_addr_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && mode_run && col_q == '0) |=>
         (!lcd_rs && lcd_data == (8'h80 | (line_q[0] ? LINE1_BASE : LINE0_BASE))));

   p_digit_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && mode_run && col_q != '0 && line_q[0]) |=>
         (lcd_rs && (lcd_data == 8'h20 || (lcd_data >= 8'h30 && lcd_data <= 8'h39))));

endmodule

bind lcd_refresh_seq lcd_refresh_seq_chk #(
   .NUM_COLS   (NUM_COLS),
   .LINE0_BASE (LINE0_BASE),
   .LINE1_BASE (LINE1_BASE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_start (slot_start),
   .col_q      (col_q),
   .line_q     (line_q),
   .mode_run   (run_mode),
   .lcd_e      (lcd_e),
   .lcd_rs     (lcd_rs),
   .lcd_rw     (lcd_rw),
   .lcd_data   (lcd_data)
);

// File: tb/test_lcd_refresh_seq.sv
module test_lcd_refresh_seq;

   localparam int          COLS = 20;
   localparam int          GL   = COLS + 1;
   localparam int          PASS = 4 * GL;
   localparam logic [159:0] TB_BANNER = "  WALL CLOCK  READY ";

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [COLS*4-1:0] digits = '0;
   logic             lcd_e, lcd_rs, lcd_rw;
   logic [7:0]       lcd_data;

   int checks = 0;
   int errors = 0;

   // behavioural model state
   int         m_n = 0;
   int         m_pos = 0;
   int         m_line = 0;
   int         m_col = 0;
   bit         m_run = 0;
   logic [7:0] m_data = 0;
   bit         m_rs = 0;
   bit         m_pulse = 0;
   string      m_tag = "R10";
   logic [COLS*4-1:0] m_shadow = '0;

   always #4 clk = ~clk;

   lcd_refresh_seq #(.NUM_COLS(COLS), .BANNER(TB_BANNER)) i_lcd_refresh_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .digits_i (digits),
      .lcd_e    (lcd_e),
      .lcd_rs   (lcd_rs),
      .lcd_rw   (lcd_rw),
      .lcd_data (lcd_data)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_n = 0; m_pos = 0; m_run = 0; m_line = 0; m_col = 0;
         m_data = 0; m_rs = 0; m_pulse = 0; m_shadow = '0; m_tag = "R10";
      end else begin
         int s;
         m_n   = m_n + 1;
         s     = (m_n - 1) / 2;
         m_pos = (m_n - 1) % 2;
         if (m_pos == 0) begin
            if (s < PASS) begin
               m_run = 0; m_rs = 0;
               m_line = s / GL; m_col = s % GL;
               if (s < 8) begin
                  m_pulse = 1; m_tag = "R4";
                  case (s)
                     4: m_data = 8'h01;
                     5: m_data = 8'h06;
                     6: m_data = 8'h0C;
                     7: m_data = 8'h80;
                     default: m_data = 8'h3C;
                  endcase
               end else begin
                  m_pulse = 0; m_data = 0; m_tag = "R5";
               end
            end else begin
               int r;
               r = (s - PASS) % PASS;
               m_run = 1; m_line = r / GL; m_col = r % GL; m_pulse = 1;
               if (m_col == 0) begin
                  if (m_line % 2 == 1) m_shadow = digits;
                  m_rs = 0; m_tag = "R6";
                  m_data = (m_line % 2 == 1) ? 8'hC0 : 8'h80;
               end else if (m_line % 2 == 0) begin
                  m_rs = 1; m_tag = "R7";
                  m_data = TB_BANNER[(COLS - m_col) * 8 +: 8];
               end else begin
                  int v;
                  v = int'(m_shadow[(m_col - 1) * 4 +: 4]);
                  m_rs = 1;
                  m_tag = (digits != m_shadow) ? "R9" : "R8";
                  m_data = (v <= 9) ? 8'(48 + v) : 8'h20;
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic sample(input bit after_neg);
      int    exp_e;
      string dtag;
      if (m_n == 0)       exp_e = 0;
      else if (after_neg) exp_e = (m_pos == 0) ? int'(m_pulse) : 0;
      else                exp_e = (m_pos == 1) ? int'(m_pulse) : 0;
      dtag = (m_n == 0) ? "R10" : ((!after_neg && m_pos == 1) ? "R2" : m_tag);
      chk("R1", "rw", int'(lcd_rw), 0);
      chk((m_n == 0) ? "R10" : "R3", "e", int'(lcd_e), exp_e);
      chk(dtag, "rs", int'(lcd_rs), int'(m_rs));
      chk(dtag, "data", int'(lcd_data), int'(m_data));
   endtask

   initial begin
      forever begin
         @(posedge clk); #2; sample(1'b0);
         @(negedge clk); #2; sample(1'b1);
      end
   end

   task automatic run_slots(input int n);
      repeat (2 * n) @(negedge clk);
   endtask

   initial begin
      fork
         begin
            digits = 80'h98765432109876543210;
            repeat (3) @(negedge clk);
            #3 rst_n = 1'b1;                       // R10 release, R4 start-up list
            run_slots(3 * PASS);                   // R5 idle, R6 R7 R8 refresh
            #3 digits = 80'h0123456789ABCDEF0F9A;  // R8 codes above 9 show blank
            run_slots(2 * PASS);
            while (!(m_run && m_line % 2 == 1 && m_col == 3)) @(negedge clk);
            #3 digits = 80'h55555555555555555555;  // R9 change inside an odd group
            run_slots(2 * PASS);
            #3 rst_n = 1'b0;                       // R10 asynchronous reset mid-pass
            repeat (3) @(negedge clk);
            #3 rst_n = 1'b1;
            #3 digits = 80'hF1E2D3C4B5A697887960;
            run_slots(3 * PASS);
         end
         begin
            repeat (200000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule